// File: doc/BRIEF.md
# Frame-Triggered FIFO Drain with Chip-Select Rotation

This block empties a byte-wide receive FIFO one frame at a time and sends the bytes out as 32-bit words on a slow external bus, aimed at one of several downstream devices through a set of chip selects. A single one-cycle frame-ready pulse from the receive clock domain starts each transfer. From then on the block counts its own way through the frame and never looks at FIFO flags. The design relies on the drain being faster than the fill.

The pulse crosses into the system clock domain as a toggle, so each pulse becomes exactly one drain request. A pulse that arrives while a frame is still going out is held in a one-deep pending flag. That frame starts as soon as the current one ends. The block counts completed frames. After a fixed number of frames it moves the chip select to the next device, and after the last device it goes back to the first. Counters and chip select change only between frames, so each select period holds whole frames only.

Top module: `frame_drain_rotator`

## Requirements
- R1: While reset is asserted, bus_cs is 3'b001 (first device), and bus_wr, bus_clk and fifo_rd_en are 0.
- R2: Each rx_frame_ready pulse (one rx_clk cycle high) causes exactly one frame drain: exactly FRAME_BYTES (162) fifo_rd_en cycles. A pop occurs only while bus_clk is low.
- R3: bus_clk runs at clk/8 during a drain, low for four clk cycles and then high for four. bus_data changes only on the clk edge where bus_clk falls. bus_wr rises only with bus_clk low, and bus_data holds through the next bus_clk rising edge, where a device samples it.
- R4: Bytes are packed in FIFO order, with the first byte in bits 7:0 and the fourth in bits 31:24. A frame gives 41 words. The last word carries bytes 160 and 161 in bits 15:0, and bits 31:16 are zero.
- R5: Exactly one bit of bus_cs is high at every clock.
- R6: After FRAMES_PER_DEV complete frames on a device, the select moves to the next device (bit 0 to bit 1 to bit 2). After the last device it wraps to bit 0, and the frame count starts again from zero.
- R7: bus_cs changes only at a frame boundary, never in a cycle where bus_wr is high.
- R8: A frame-ready pulse received while a frame is draining is kept and its frame is drained right after the current one. No frame is lost as long as at most one pulse is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| rx_clk | input | 1 | Receive-domain clock |
| rx_frame_ready | input | 1 | One-cycle pulse in rx_clk domain: one frame is ready in the FIFO |
| fifo_rd_en | output | 1 | Pop strobe to a first-word-fall-through FIFO |
| fifo_rd_data | input | 8 | Byte at the FIFO head |
| bus_clk | output | 1 | External bus clock, clk/8 while draining, low when idle |
| bus_wr | output | 1 | bus_data holds a valid word for this bus period |
| bus_data | output | 32 | Packed word |
| bus_cs | output | NUM_DEV | One-hot active-high device select |

## Verification
The hardest case to reach is a frame-ready pulse that lands in the middle of a drain and must be held pending. The pending frame must then start at the end of the current frame. That same boundary may also be the one where the chip select moves on. The stimulus table mixes long gaps with 40-cycle gaps after a pulse, so some frames queue behind a busy drain. The per-device frame limit is set to three, so rotation and wrap-around fall inside those back-to-back pairs. A monitor acting as the receiving device checks every word against the bytes written and against the device expected for that frame.

// File: rtl/frame_drain_rotator.sv
module frame_drain_rotator #(
  parameter int FRAME_BYTES    = 162,
  parameter int FRAMES_PER_DEV = 128 * 512,
  parameter int NUM_DEV        = 3,
  parameter int CLK_DIV        = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_clk,
  input  logic               rx_frame_ready,
  output logic               fifo_rd_en,
  input  logic [7:0]         fifo_rd_data,
  output logic               bus_clk,
  output logic               bus_wr,
  output logic [31:0]        bus_data,
  output logic [NUM_DEV-1:0] bus_cs
);
  localparam int WORDS = (FRAME_BYTES + 3) / 4;
  localparam int TAIL  = FRAME_BYTES - 4 * (WORDS - 1);
  localparam int WW    = $clog2(WORDS + 2);
  localparam int PW    = $clog2(CLK_DIV);
  localparam int FW    = $clog2(FRAMES_PER_DEV + 1);
  localparam int DW    = $clog2(NUM_DEV + 1);

  logic rx_tog;
  always_ff @(posedge rx_clk or negedge rst_n)
    if (!rst_n) rx_tog <= 1'b0;
    else if (rx_frame_ready) rx_tog <= ~rx_tog;

  logic [2:0] sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else sync <= {sync[1:0], rx_tog};

  wire kick = sync[2] ^ sync[1];

  logic          busy, pend;
  logic [PW-1:0] phase;
  logic [WW-1:0] word;
  logic [31:0]   pack;
  logic [FW-1:0] fcnt;
  logic [DW-1:0] dev;

  wire last_phase = phase == PW'(CLK_DIV - 1);
  wire frame_end  = busy && last_phase && word == WW'(WORDS);

  assign fifo_rd_en = busy && word < WW'(WORDS) && phase < PW'(4) &&
                      (word != WW'(WORDS - 1) || phase < PW'(TAIL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      phase    <= '0;
      word     <= '0;
      pack     <= '0;
      fcnt     <= '0;
      dev      <= '0;
      bus_clk  <= 1'b0;
      bus_wr   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_clk <= busy && phase >= PW'(CLK_DIV / 2 - 1) && !last_phase;

      if (!busy) begin
        if (kick || pend) begin
          busy  <= 1'b1;
          pend  <= 1'b0;
          phase <= '0;
          word  <= '0;
        end
      end else begin
        phase <= last_phase ? '0 : phase + 1'b1;
        if (last_phase) word <= word + 1'b1;
        if (kick) pend <= 1'b1;
        if (frame_end) begin
          word <= '0;
          busy <= pend | kick;
          pend <= pend & kick;
          if (fcnt == FW'(FRAMES_PER_DEV - 1)) begin
            fcnt <= '0;
            dev  <= (dev == DW'(NUM_DEV - 1)) ? '0 : dev + 1'b1;
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end
      end

      if (fifo_rd_en) begin
        if (phase == '0) pack <= {24'b0, fifo_rd_data};
        else pack[8*phase[1:0] +: 8] <= fifo_rd_data;
      end

      if (busy && last_phase) begin
        if (word < WW'(WORDS)) begin
          bus_data <= pack;
          bus_wr   <= 1'b1;
        end else begin
          bus_wr <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
    assign bus_cs[i] = dev == DW'(i);
  end
endmodule

// File: rtl/frame_drain_checker.sv
module frame_drain_checker #(
  parameter int NUM_DEV = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_clk,
  input logic               bus_wr,
  input logic               fifo_rd_en,
  input logic [31:0]        bus_data,
  input logic [NUM_DEV-1:0] bus_cs
);
  a_r5_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_cs) == 1);

  a_r7_cs_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_cs) |-> !bus_wr);

  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> $stable(bus_data));

  a_r3_wr_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> !bus_clk);

  a_r2_pop_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !bus_clk);
endmodule

bind frame_drain_rotator frame_drain_checker #(.NUM_DEV(NUM_DEV)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_clk    (bus_clk),
  .bus_wr     (bus_wr),
  .fifo_rd_en (fifo_rd_en),
  .bus_data   (bus_data),
  .bus_cs     (bus_cs)
);

// File: tb/test_frame_drain_rotator.sv
module test_frame_drain_rotator;
  localparam int FB = 162;
  localparam int NW = 41;
  localparam int FPD = 3;
  localparam int NT = 10;
  localparam int GAP  [NT] = '{360, 40, 700, 400, 40, 700, 360, 360, 40, 700};
  localparam int EXPD [NT] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 0};

  logic clk = 0, rx_clk = 0, rst_n = 0, rx_frame_ready = 0;
  logic fifo_rd_en, bus_clk, bus_wr;
  logic [7:0] fifo_rd_data;
  logic [31:0] bus_data;
  logic [2:0] bus_cs;

  always #4 clk = ~clk;
  always #5 rx_clk = ~rx_clk;

  frame_drain_rotator #(.FRAMES_PER_DEV(FPD)) i_frame_drain_rotator (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_frame_ready(rx_frame_ready),
    .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data), .bus_clk(bus_clk),
    .bus_wr(bus_wr), .bus_data(bus_data), .bus_cs(bus_cs));

  int nchk = 0, nbad = 0, nsent = 0, pops = 0, words = 0, fnum = 0, wcnt = 0;
  bit done = 0;
  logic [7:0] mem [0:1023];
  logic [9:0] wptr = 0, rptr = 0, mptr = 0;
  int exp_dev [0:31];

  assign fifo_rd_data = mem[rptr];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk)
    if (!rst_n) begin rptr <= 0; pops <= 0; end
    else if (fifo_rd_en) begin rptr <= rptr + 1; pops <= pops + 1; end

  always @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      mptr = 0; wcnt = 0; fnum = 0; words = 0;
    end else if (bus_wr) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++)
        e[8*b +: 8] = (wcnt == NW - 1 && b >= 2) ? 8'h00 : mem[mptr + 10'(b)];
      check(bus_data == e, "R4 word", bus_data, e);
      check(bus_cs == 3'(1 << exp_dev[fnum]), "R6 device", 32'(bus_cs), 32'(1 << exp_dev[fnum]));
      mptr = mptr + ((wcnt == NW - 1) ? 10'd2 : 10'd4);
      words++;
      if (wcnt == NW - 1) begin wcnt = 0; fnum++; end
      else wcnt++;
    end
  end

  task automatic send_frame(input int seed, input int dev);
    for (int i = 0; i < FB; i++) begin
      mem[wptr] = 8'(seed * 13 + i * 7 + 1);
      wptr = wptr + 1;
    end
    exp_dev[nsent] = dev;
    nsent++;
    @(negedge rx_clk) rx_frame_ready = 1;
    @(negedge rx_clk) rx_frame_ready = 0;
  endtask

  task automatic wait_words(input int n, input string req);
    int t = 0;
    while (words < n && t < 30000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    check(words == n, req, 32'(words), 32'(n));
  endtask

  task automatic check_reset_state;
    check(bus_cs == 3'b001, "R1 cs", 32'(bus_cs), 32'h1);
    check(!bus_wr && !bus_clk && !fifo_rd_en, "R1 idle outputs",
          {29'b0, bus_wr, bus_clk, fifo_rd_en}, 32'h0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) check_reset_state();
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NT; i++) begin
      send_frame(i, EXPD[i]);
      repeat (GAP[i]) @(negedge clk);
    end
    wait_words(NT * NW, "R8 all queued frames drained");
    check(pops == NT * FB, "R2 pop count", 32'(pops), 32'(NT * FB));
    check(!bus_wr && !bus_clk, "R3 idle bus", {30'b0, bus_wr, bus_clk}, 32'h0);

    send_frame(50, 0);
    repeat (400) @(negedge clk);
    send_frame(51, 0);
    wait_words((NT + 2) * NW, "R6 wrap frames drained");
    check(bus_cs == 3'b010, "R6 moved after third frame", 32'(bus_cs), 32'h2);
    check(pops == (NT + 2) * FB, "R2 pop count", 32'(pops), 32'((NT + 2) * FB));

    send_frame(60, 1);
    repeat (100) @(negedge clk);
    rst_n = 0;
    wptr = 0; nsent = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1;
    repeat (3) @(negedge clk);
    send_frame(70, 0);
    wait_words(NW, "R2 frame after reset");
    check(pops == FB, "R2 pop count after reset", 32'(pops), 32'(FB));
    check(bus_cs == 3'b001, "R1 first device kept", 32'(bus_cs), 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", words, nsent * NW);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule